// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Port

This block is a byte-wide synchronous serial port that shifts one byte out and one byte in at the same time, most significant bit first. It works either as the clock owner, driving the serial clock from a divided system clock or from an external timer pulse, or as a follower that takes the serial clock from outside. In follower mode an optional select input gates the shifting. The processor side is a set of strobes and levels: a data write, a data read, configuration levels, and sticky status flags with their clear strobes.

A received byte is copied into a holding register as soon as its last bit is sampled, so the next byte can start shifting before software has read the previous one. A data write made while a byte is moving is dropped and raises a collision flag. In clock-owner mode, a write while idle starts a transfer. In follower mode, it preloads the byte sent on the next clock sequence.

Top module: `spi_port`

## Requirements
- R1: After reset, `rdata_o` is 0x00, `bf_o`, `wcol_o` and `irq_o` are 0, and with `master_i`=1 the serial clock output rests at the level of `cpol_i`.
- R2: With `master_i`=1, a write while idle starts a transfer. The byte on `sdo_o` goes out MSB first, the byte on `sdi_i` comes in MSB first, and the received byte appears on `rdata_o` with `bf_o` and `irq_o` set.
- R3: `clk_sel_i` 0, 1 and 2 give a serial clock half period of 2, 8 and 32 system clocks. Counting the write edge as cycle 0, `bf_o` rises at cycle H*(n+1), where H is the half period and n is the index (0 to 16) of the half-period tick that takes the last sample.
- R4: `clk_sel_i`=3 advances the serial clock by one half period for each `tmr_tick_i` pulse. With `cpha_i`=0 and `smp_i`=0, `bf_o` rises on the 15th pulse after the write.
- R5: A clock-owner transfer gives exactly 16 serial clock transitions and then returns the clock to the `cpol_i` level. With `cpha_i`=0 the first bit is on `sdo_o` before the first edge, data is sampled on edges going away from idle, and data changes on edges returning to idle. `cpha_i`=1 swaps the two roles.
- R6: With `master_i`=1 and `smp_i`=1, each bit is sampled one half period later (at the end of its output time), so the last sample index n grows by one. With `cpha_i`=0 the last sample is at tick 14 when `smp_i`=0 and at tick 15 when `smp_i`=1. With `cpha_i`=1 these become 15 and 16.
- R7: With `master_i`=0, `sck_i`, `sdi_i` and `ss_ni` pass through a two-flip-flop synchronizer. A byte written while idle is sent MSB first on `sck_i` edges and a byte is received. `bf_o` rises on the third system clock edge after the `sck_i` edge that carries the last sample.
- R8: With `master_i`=0 and `ss_en_i`=1, a high `ss_ni` sets `sdo_oe_o` to 0 and discards a partly received byte. The next full byte after `ss_ni` goes low is received correctly.
- R9: While `bf_o` is still set, a new received byte replaces `rdata_o` and `bf_o` stays 1.
- R10: A write during a transfer does not change the byte being sent and sets `wcol_o`. `wcol_o` stays 1 until a `wcol_clr_i` pulse.
- R11: A `rd_i` pulse clears `bf_o` and leaves `irq_o` set. Only an `irq_clr_i` pulse clears `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = port drives the serial clock |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0 = sample on leading edge, 1 = change on leading edge |
| smp_i | input | 1 | Clock-owner sample at end of bit time |
| ss_en_i | input | 1 | Follower: honour the select input |
| clk_sel_i | input | 2 | 0: /4, 1: /16, 2: /64, 3: timer pulses |
| tmr_tick_i | input | 1 | External timer pulse |
| wr_i | input | 1 | Write strobe for the data register |
| wdata_i | input | 8 | Byte to send |
| rd_i | input | 1 | Read strobe, clears buffer full |
| rdata_o | output | 8 | Last received byte |
| wcol_clr_i | input | 1 | Clears the collision flag |
| irq_clr_i | input | 1 | Clears the interrupt request |
| bf_o | output | 1 | Received byte waiting |
| wcol_o | output | 1 | Write collision flag |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from outside (follower) |
| sck_o | output | 1 | Serial clock driven (clock owner) |
| sck_oe_o | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data out enable |
| ss_ni | input | 1 | Select input, active low |

## Verification
In clock-owner mode the result is due at cycle H*(n+1) after the write edge. The bench computes this cycle from the divider and the clock-mode settings. It samples `bf_o` one cycle before that cycle, where it must still be 0, and at that cycle, where it must be 1. In timer mode the bench gives pulses one at a time and checks the flag after the 14th and the 15th pulse. In follower mode the bench counts the synchronizer latency of three system clock edges from its own `sck_i` edge, and samples `sdo_o` a full six-cycle half period after each edge it drives. All samples are taken at the falling system clock edge.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  typedef enum logic [1:0] {
    CLK_DIV_A = 2'd0,
    CLK_DIV_B = 2'd1,
    CLK_DIV_C = 2'd2,
    CLK_TMR   = 2'd3
  } clk_sel_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[0] <= '0;
        else         st_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_clk_gen.sv
`timescale 1ns/1ps
module spi_clk_gen
  import spi_port_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  clk_sel_e sel_i,
  input  logic     tmr_tick_i,
  output logic     tick_o
);
  localparam int HALF_MAX = DIV_C / 2;
  localparam int CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [CW-1:0] cnt_q, lim;

  always_comb begin
    unique case (sel_i)
      CLK_DIV_A: lim = CW'(DIV_A / 2 - 1);
      CLK_DIV_B: lim = CW'(DIV_B / 2 - 1);
      CLK_DIV_C: lim = CW'(DIV_C / 2 - 1);
      default:   lim = '0;
    endcase
  end

  assign tick_o = en_i & ((sel_i == CLK_TMR) ? tmr_tick_i : (cnt_q == lim));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/spi_engine.sv
`timescale 1ns/1ps
module spi_engine #(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            master_i,
  input  logic            cpha_i,
  input  logic            smp_i,
  input  logic            load_i,
  input  logic [BITS-1:0] load_data_i,
  input  logic            start_i,
  input  logic            clr_i,
  input  logic            ev_i,
  input  logic            sdi_i,
  output logic            sdo_o,
  output logic            sck_ph_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [BITS-1:0] rx_byte_o
);
  localparam int EDGES = 2 * BITS;
  localparam int KW    = $clog2(EDGES + 1);
  localparam int CW    = $clog2(BITS);
  localparam logic [KW-1:0] K_END  = KW'(EDGES);
  localparam logic [KW-1:0] K_LAST = KW'(EDGES - 1);
  localparam logic [CW-1:0] C_LAST = CW'(BITS - 1);

  logic [KW-1:0]   k_q, k_nxt;
  logic [CW-1:0]   scnt_q;
  logic [BITS-1:0] tx_q, rx_q;
  logic            run_q, ph_q;
  logic            at_end, chg_par, late, sample_ev, shift_ev;

  // k counts serial clock half periods; k == EDGES is the closing tick (master only)
  always_comb begin
    at_end    = (k_q == K_END);
    chg_par   = k_q[0] ^ cpha_i;
    late      = master_i & smp_i;
    sample_ev = ev_i & (late ? ((k_q != '0) & chg_par) : (~at_end & ~chg_par));
    shift_ev  = ev_i & chg_par & (k_q != '0) & (k_q < K_LAST);
    done_o    = sample_ev & (scnt_q == C_LAST);
    rx_byte_o = {rx_q[BITS-2:0], sdi_i};
    if (master_i ? at_end : (k_q == K_LAST)) k_nxt = '0;
    else                                     k_nxt = k_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q    <= '0;
      scnt_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      if (clr_i) begin
        k_q    <= '0;
        scnt_q <= '0;
      end else if (start_i) begin
        k_q    <= '0;
        scnt_q <= '0;
        run_q  <= 1'b1;
        ph_q   <= 1'b0;
      end else if (ev_i) begin
        k_q <= k_nxt;
        if (master_i && !at_end) ph_q  <= ~ph_q;
        if (master_i && at_end)  run_q <= 1'b0;
        if (sample_ev) begin
          rx_q   <= rx_byte_o;
          scnt_q <= done_o ? '0 : scnt_q + 1'b1;
        end
      end
      if (load_i)                           tx_q <= load_data_i;
      else if (shift_ev && !clr_i && !start_i) tx_q <= {tx_q[BITS-2:0], 1'b0};
    end
  end

  assign sdo_o    = tx_q[BITS-1];
  assign sck_ph_o = ph_q;
  assign busy_o   = master_i ? run_q : (k_q != '0);
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
  import spi_port_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            master_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  input  logic            smp_i,
  input  logic            ss_en_i,
  input  logic [1:0]      clk_sel_i,
  input  logic            tmr_tick_i,
  input  logic            wr_i,
  input  logic [BITS-1:0] wdata_i,
  input  logic            rd_i,
  output logic [BITS-1:0] rdata_o,
  input  logic            wcol_clr_i,
  input  logic            irq_clr_i,
  output logic            bf_o,
  output logic            wcol_o,
  output logic            irq_o,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            sck_oe_o,
  input  logic            sdi_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  input  logic            ss_ni
);
  logic [2:0] pins_s;
  logic       sck_s, sdi_s, ss_s, sck_prev_q;
  logic       tick, slave_edge, ev, ss_off;
  logic       eng_busy, eng_done, eng_ph, eng_sdi;
  logic       start, load;
  logic [BITS-1:0] eng_rx, rbuf_q;
  logic       bf_q, wcol_q, irq_q;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sdi_i, sck_i}),
    .q_o   (pins_s)
  );
  assign {ss_s, sdi_s, sck_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck_s;

  spi_clk_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (master_i & eng_busy),
    .sel_i     (clk_sel_e'(clk_sel_i)),
    .tmr_tick_i(tmr_tick_i),
    .tick_o    (tick)
  );

  assign ss_off     = ~master_i & ss_en_i & ss_s;
  assign slave_edge = ~master_i & ~ss_off & (sck_s ^ sck_prev_q);
  assign ev         = master_i ? tick : slave_edge;
  assign load       = wr_i & ~eng_busy;
  assign start      = load & master_i;
  assign eng_sdi    = master_i ? sdi_i : sdi_s;

  spi_engine #(.BITS(BITS)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .master_i   (master_i),
    .cpha_i     (cpha_i),
    .smp_i      (smp_i),
    .load_i     (load),
    .load_data_i(wdata_i),
    .start_i    (start),
    .clr_i      (ss_off),
    .ev_i       (ev),
    .sdi_i      (eng_sdi),
    .sdo_o      (sdo_o),
    .sck_ph_o   (eng_ph),
    .busy_o     (eng_busy),
    .done_o     (eng_done),
    .rx_byte_o  (eng_rx)
  );

  // set wins over clear on every sticky flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q <= '0;
      bf_q   <= 1'b0;
      wcol_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (eng_done) rbuf_q <= eng_rx;
      if (eng_done)         bf_q <= 1'b1;
      else if (rd_i)        bf_q <= 1'b0;
      if (eng_done)         irq_q <= 1'b1;
      else if (irq_clr_i)   irq_q <= 1'b0;
      if (wr_i && eng_busy) wcol_q <= 1'b1;
      else if (wcol_clr_i)  wcol_q <= 1'b0;
    end
  end

  assign rdata_o  = rbuf_q;
  assign bf_o     = bf_q;
  assign wcol_o   = wcol_q;
  assign irq_o    = irq_q;
  assign sck_o    = cpol_i ^ eng_ph;
  assign sck_oe_o = master_i;
  assign sdo_oe_o = master_i | ~(ss_en_i & ss_s);
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk #(
  parameter int BITS = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            master_i,
  input logic            cpol_i,
  input logic            ss_en_i,
  input logic            wr_i,
  input logic            rd_i,
  input logic            wcol_clr_i,
  input logic            irq_clr_i,
  input logic            sck_o,
  input logic            bf_o,
  input logic            wcol_o,
  input logic            irq_o,
  input logic [BITS-1:0] rdata_o,
  input logic            busy_i,
  input logic            done_i,
  input logic            ss_sync_i
);
  a_r1_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !busy_i) |-> (sck_o == cpol_i));

  a_r10_wcol_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i) |=> wcol_o);

  a_r10_wcol_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !wcol_clr_i) |=> wcol_o);

  a_r11_bf_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !bf_o);

  a_r11_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(rdata_o));

  a_r8_deselect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && ss_en_i && ss_sync_i) |=> !busy_i);
endmodule

bind spi_port spi_port_chk #(.BITS(BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .cpol_i    (cpol_i),
  .ss_en_i   (ss_en_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .wcol_clr_i(wcol_clr_i),
  .irq_clr_i (irq_clr_i),
  .sck_o     (sck_o),
  .bf_o      (bf_o),
  .wcol_o    (wcol_o),
  .irq_o     (irq_o),
  .rdata_o   (rdata_o),
  .busy_i    (eng_busy),
  .done_i    (eng_done),
  .ss_sync_i (ss_s)
);

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       master_i = 1'b1, cpol_i = 1'b0, cpha_i = 1'b0, smp_i = 1'b0, ss_en_i = 1'b0;
  logic [1:0] clk_sel_i = 2'd0;
  logic       tmr_tick_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, wcol_clr_i = 1'b0, irq_clr_i = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       bf_o, wcol_o, irq_o, sck_o, sck_oe_o, sdo_o, sdo_oe_o;
  logic       sck_drv = 1'b0, sdi_drv = 1'b0, ss_ni = 1'b0, loop_en = 1'b1;
  logic       sdi_i;
  int         n_chk = 0, n_bad = 0;
  int         edge_cnt = 0;
  logic       edge_clr = 1'b0, sck_d = 1'b0;
  localparam int SH = 6;

  assign sdi_i = loop_en ? sdo_o : sdi_drv;

  always #4 clk_i = ~clk_i;  // 125 MHz

  spi_port u_spi_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i), .cpol_i(cpol_i),
    .cpha_i(cpha_i), .smp_i(smp_i), .ss_en_i(ss_en_i), .clk_sel_i(clk_sel_i),
    .tmr_tick_i(tmr_tick_i), .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .wcol_clr_i(wcol_clr_i), .irq_clr_i(irq_clr_i),
    .bf_o(bf_o), .wcol_o(wcol_o), .irq_o(irq_o), .sck_i(sck_drv),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .sdi_i(sdi_i), .sdo_o(sdo_o),
    .sdo_oe_o(sdo_oe_o), .ss_ni(ss_ni)
  );

  always @(posedge clk_i) begin
    if (edge_clr) edge_cnt <= 0;
    else if (sck_o != sck_d) edge_cnt <= edge_cnt + 1;
    sck_d <= sck_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk_i); wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk_i); rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk_i); irq_clr_i = 1'b1; @(negedge clk_i); irq_clr_i = 1'b0;
  endtask

  task automatic wait_bf(input int limit);
    for (int i = 0; i < limit && !bf_o; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    check(rdata_o == 8'h00, "R1 rdata", rdata_o, 0);
    check({bf_o, wcol_o, irq_o} == 3'b000, "R1 flags", {bf_o, wcol_o, irq_o}, 0);
    check(sck_o == cpol_i, "R1 sck idle", sck_o, cpol_i);
  endtask

  // clock-owner transfer with loopback; exact completion cycle
  task automatic t_master(input logic [1:0] sel, input logic pol, input logic pha,
                          input logic sp, input logic [7:0] d);
    int h, idx, t;
    h   = (sel == 2'd0) ? 2 : (sel == 2'd1) ? 8 : 32;
    idx = 14 + int'(pha) + int'(sp);
    t   = h * (idx + 1);
    @(negedge clk_i);
    master_i = 1'b1; loop_en = 1'b1; clk_sel_i = sel; cpol_i = pol; cpha_i = pha; smp_i = sp;
    cycles(2);
    check(sck_o == pol, "R5 idle before", sck_o, pol);
    edge_clr = 1'b1; @(negedge clk_i); edge_clr = 1'b0;
    write(d);
    cycles(t - 1);
    check(bf_o == 1'b0, "R3/R6 not early", bf_o, 0);
    @(negedge clk_i);
    check(bf_o == 1'b1, "R3/R6 on time", bf_o, 1);
    check(rdata_o == d, "R2 data", rdata_o, d);
    check(irq_o == 1'b1, "R2 irq", irq_o, 1);
    cycles(2 * h + 4);
    check(edge_cnt == 16, "R5 edge count", edge_cnt, 16);
    check(sck_o == pol, "R5 idle after", sck_o, pol);
    pulse_rd();
    check(bf_o == 1'b0, "R11 read clears bf", bf_o, 0);
    check(irq_o == 1'b1, "R11 irq kept", irq_o, 1);
    pulse_irq_clr();
    check(irq_o == 1'b0, "R11 irq clear", irq_o, 0);
  endtask

  task automatic t_timer();
    @(negedge clk_i);
    master_i = 1'b1; loop_en = 1'b1; clk_sel_i = 2'd3; cpol_i = 1'b0; cpha_i = 1'b0; smp_i = 1'b0;
    edge_clr = 1'b1; @(negedge clk_i); edge_clr = 1'b0;
    write(8'h6B);
    for (int p = 1; p <= 17; p++) begin
      cycles(2);
      tmr_tick_i = 1'b1; @(negedge clk_i); tmr_tick_i = 1'b0;
      if (p == 14) check(bf_o == 1'b0, "R4 after 14 pulses", bf_o, 0);
      if (p == 15) begin
        check(bf_o == 1'b1, "R4 after 15 pulses", bf_o, 1);
        check(rdata_o == 8'h6B, "R4 data", rdata_o, 8'h6B);
      end
    end
    cycles(2);
    check(edge_cnt == 16, "R4 edge count", edge_cnt, 16);
    pulse_rd(); pulse_irq_clr();
  endtask

  task automatic t_wcol();
    @(negedge clk_i);
    master_i = 1'b1; loop_en = 1'b1; clk_sel_i = 2'd0; cpol_i = 1'b0; cpha_i = 1'b0; smp_i = 1'b0;
    write(8'h96);
    cycles(5);
    write(8'h11);
    check(wcol_o == 1'b1, "R10 collision set", wcol_o, 1);
    wait_bf(100);
    check(rdata_o == 8'h96, "R10 byte unchanged", rdata_o, 8'h96);
    cycles(20);
    check(wcol_o == 1'b1, "R10 sticky", wcol_o, 1);
    @(negedge clk_i); wcol_clr_i = 1'b1; @(negedge clk_i); wcol_clr_i = 1'b0;
    check(wcol_o == 1'b0, "R10 cleared", wcol_o, 0);
    pulse_rd(); pulse_irq_clr();
  endtask

  task automatic t_dbuf();
    @(negedge clk_i);
    master_i = 1'b1; loop_en = 1'b1; clk_sel_i = 2'd0; cpha_i = 1'b0; smp_i = 1'b0;
    write(8'h12);
    cycles(40);
    check(rdata_o == 8'h12, "R9 first byte", rdata_o, 8'h12);
    write(8'h34);
    cycles(40);
    check(rdata_o == 8'h34, "R9 overwrite", rdata_o, 8'h34);
    check(bf_o == 1'b1, "R9 bf kept", bf_o, 1);
    pulse_rd(); pulse_irq_clr();
  endtask

  // bench drives sck_i as the clock owner, cpol = 0
  task automatic slave_bits(input logic pha, input logic [7:0] mosi, input int nbits,
                            input bit chk_time, output logic [7:0] miso);
    miso = '0;
    for (int i = 0; i < nbits; i++) begin
      if (!pha) begin
        sdi_drv = mosi[7-i];
        cycles(SH);
        miso[7-i] = sdo_o;
        sck_drv = 1'b1;
        if (chk_time && i == 7) begin
          cycles(2);
          check(bf_o == 1'b0, "R7 not early", bf_o, 0);
          @(negedge clk_i);
          check(bf_o == 1'b1, "R7 on time", bf_o, 1);
          cycles(SH - 3);
        end else cycles(SH);
        sck_drv = 1'b0;
      end else begin
        sck_drv = 1'b1;
        sdi_drv = mosi[7-i];
        cycles(SH);
        miso[7-i] = sdo_o;
        sck_drv = 1'b0;
        if (chk_time && i == 7) begin
          cycles(2);
          check(bf_o == 1'b0, "R7 not early", bf_o, 0);
          @(negedge clk_i);
          check(bf_o == 1'b1, "R7 on time", bf_o, 1);
          cycles(SH - 3);
        end else cycles(SH);
      end
    end
    cycles(SH);
  endtask

  task automatic t_slave(input logic pha, input logic [7:0] pre, input logic [7:0] mosi);
    logic [7:0] miso;
    @(negedge clk_i);
    master_i = 1'b0; loop_en = 1'b0; cpol_i = 1'b0; cpha_i = pha; ss_en_i = 1'b0;
    sck_drv = 1'b0; ss_ni = 1'b0;
    cycles(4);
    write(pre);
    cycles(2);
    slave_bits(pha, mosi, 8, 1'b1, miso);
    check(rdata_o == mosi, "R7 received", rdata_o, mosi);
    check(miso == pre, "R7 sent", miso, pre);
    pulse_rd(); pulse_irq_clr();
  endtask

  task automatic t_select();
    logic [7:0] miso;
    @(negedge clk_i);
    master_i = 1'b0; loop_en = 1'b0; cpol_i = 1'b0; cpha_i = 1'b0; ss_en_i = 1'b1;
    sck_drv = 1'b0; ss_ni = 1'b0;
    cycles(4);
    write(8'hC3);
    cycles(2);
    slave_bits(1'b0, 8'hF0, 4, 1'b0, miso);
    ss_ni = 1'b1;
    cycles(4);
    check(sdo_oe_o == 1'b0, "R8 sdo released", sdo_oe_o, 0);
    check(bf_o == 1'b0, "R8 no byte", bf_o, 0);
    write(8'hC3);
    ss_ni = 1'b0;
    cycles(4);
    check(sdo_oe_o == 1'b1, "R8 sdo driven", sdo_oe_o, 1);
    slave_bits(1'b0, 8'h5A, 8, 1'b0, miso);
    check(rdata_o == 8'h5A, "R8 clean byte", rdata_o, 8'h5A);
    check(miso == 8'hC3, "R8 sent byte", miso, 8'hC3);
    pulse_rd(); pulse_irq_clr();
    ss_en_i = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    cycles(3);
    rst_ni = 1'b1;
    cycles(4);
    t_reset();
    t_master(2'd0, 1'b0, 1'b0, 1'b0, 8'hA5);
    t_master(2'd1, 1'b1, 1'b1, 1'b0, 8'h3C);
    t_master(2'd2, 1'b0, 1'b1, 1'b1, 8'h81);
    t_master(2'd0, 1'b1, 1'b0, 1'b1, 8'h7E);
    t_timer();
    t_wcol();
    t_dbuf();
    t_slave(1'b0, 8'hB4, 8'h2D);
    t_slave(1'b1, 8'h59, 8'hE6);
    t_select();
    summary();
  end
endmodule